// File: doc/BRIEF.md
# Preemptible Partial Reconfiguration Loader

This block streams configuration frames for hardware modules into a reconfigurable region. A requester names a module by its id with a single-cycle, non-blocking request. The block then reads that module's frames, one word per frame, from a word-addressed memory. It forwards each word to a downstream configuration port over a valid/ready handshake. Each module has a fixed frame count and a base address, both set by parameters. A per-module progress counter records how many frames have been written, so a load that is interrupted resumes at the frame where it stopped.

The block keeps one resident flag per module. A module's flag is set when its final frame is written. Modules can overlap in the region, and a parameter matrix lists which pairs conflict. Starting a load therefore clears the flag and the saved progress of every module that conflicts with the one being loaded. Modules that do not overlap it stay resident. A request for a different module while a load is running preempts the running load at once. A request that has nothing to do is dropped, and every request is acknowledged one cycle later.

The control is a two-state machine:
- `ST_IDLE` means no load is active.
- `ST_LOAD` means frames of module `busy_id` are being offered.

The transitions are:
- IDLE→LOAD on a start request.
- LOAD→LOAD on a preempting request, which switches the current module.
- LOAD→IDLE when the last frame is accepted and no start request arrives in the same cycle.

A request decoder sorts each request into one of three classes: none, drop or start.

Top module: `reconfig_loader`

## Requirements
- R1: After reset `busy_id` is all ones (3'b111 with the default four modules), meaning idle. `resident` is 0, and `cfg_valid`, `done` and `req_ack` are 0.
- R2: A request for an in-range, non-resident module takes effect in the cycle after `req_valid`. From then, `busy_id` equals the requested id and `cfg_valid` is 1. `mem_addr` equals the module's base address plus its saved progress.
- R3: One frame is accepted on each clock edge where `cfg_valid` and `cfg_ready` are both 1. `mem_addr` then advances by one. `cfg_data` always equals `mem_rdata`. While `cfg_ready` is 0, `mem_addr` and `busy_id` hold.
- R4: In the cycle after the last frame is accepted, the block reports completion:
  - `done` is 1 for one cycle and `done_id` names the module.
  - The module's `resident` bit is 1.
  - `busy_id` returns to all ones.
- R5: Starting a load clears the `resident` bit and the saved progress of every module that conflicts with the one being loaded. Default conflicts are 0–1 and 1–2; module 3 conflicts with none. Non-conflicting modules keep their `resident` bit.
- R6: A start request for a different module during a load switches to the new module in the next cycle. The preempted module keeps its progress, and a later request resumes it at that frame.
- R7: The following requests are dropped and leave `busy_id`, `mem_addr` and `resident` unchanged:
  - a request for a resident module;
  - a request for the module currently loading;
  - a request with an id of `NUM_MODS` or more.

  `req_ack` is 1 in the cycle after every request.
- R8: `query_loaded` equals the `resident` bit of `query_id`. It is 0 when `query_id` is out of range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request strobe |
| req_id | input | ID_W | Module id of the request |
| req_ack | output | 1 | Request acknowledged (one cycle after the request) |
| busy_id | output | ID_W | Module being loaded, all ones when idle |
| query_id | input | ID_W | Module id to query |
| query_loaded | output | 1 | Queried module is fully resident |
| resident | output | NUM_MODS | Resident flag per module |
| mem_addr | output | ADDR_W | Word address of the current frame |
| mem_rdata | input | DATA_W | Word read at `mem_addr` (combinational memory) |
| cfg_valid | output | 1 | Frame offered to the configuration port |
| cfg_ready | input | 1 | Configuration port accepts a frame |
| cfg_data | output | DATA_W | Frame word |
| done | output | 1 | Last frame of a module written |
| done_id | output | ID_W | Module that completed |

## Verification
The bench resumes a preempted module and checks that addressing continues at the saved frame. A design that discarded progress would restart at the base address. It also restarts a module whose region a conflicting load overwrote, which must start again from the base address; a design that forgot to reset the saved count would resume mid-module. Dropped requests are checked at the ports: a resident module, the module already loading, and an out-of-range id must leave `busy_id` and `mem_addr` unchanged. A design that started or restarted such a load would show a changed id or address. Backpressure and the completion cycle are also checked. A design that advanced while `cfg_ready` was low, or left a conflicting module marked resident, fails there.

// File: rtl/reconfig_pkg.sv
package reconfig_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_LOAD = 1'b1
    } ld_state_e;

    typedef enum logic [1:0] {
        RQ_NONE  = 2'd0,
        RQ_DROP  = 2'd1,
        RQ_START = 2'd2
    } rq_kind_e;

endpackage

// File: rtl/rl_req_decode.sv
module rl_req_decode
    import reconfig_pkg::*;
#(
    parameter int NUM_MODS = 4,
    parameter int ID_W     = 3,
    parameter logic [NUM_MODS*NUM_MODS-1:0] CONFLICT = '0
) (
    input  logic                req_valid,
    input  logic [ID_W-1:0]     req_id,
    input  logic [NUM_MODS-1:0] resident,
    input  logic                loading,
    input  logic [ID_W-1:0]     cur_id,
    output rq_kind_e            kind,
    output logic [NUM_MODS-1:0] clr_mask
);

    logic                in_range;
    logic                hit_res;
    logic [NUM_MODS-1:0] row;

    // Classify the request and look up the conflict row of the target.
    always_comb begin
        in_range = (req_id < ID_W'(NUM_MODS));
        hit_res  = 1'b0;
        row      = '0;
        for (int k = 0; k < NUM_MODS; k++) begin
            if (req_id == ID_W'(k)) begin
                hit_res = resident[k];
                row     = CONFLICT[k*NUM_MODS +: NUM_MODS];
                row[k]  = 1'b0;
            end
        end

        kind     = RQ_NONE;
        clr_mask = '0;
        if (req_valid) begin
            if (!in_range || hit_res || (loading && (req_id == cur_id))) begin
                kind = RQ_DROP;
            end else begin
                kind     = RQ_START;
                clr_mask = row;
            end
        end
    end

endmodule

// File: rtl/rl_progress_bank.sv
module rl_progress_bank #(
    parameter int NUM_MODS = 4,
    parameter int CNT_W    = 4,
    parameter int ID_W     = 3,
    parameter logic [NUM_MODS*CNT_W-1:0] FRAMES = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                xfer,
    input  logic [ID_W-1:0]     cur_id,
    input  logic [NUM_MODS-1:0] clr_mask,
    output logic [NUM_MODS-1:0] resident,
    output logic [CNT_W-1:0]    cur_prog,
    output logic                last_frame
);

    logic [CNT_W-1:0] prog_q [NUM_MODS];
    logic             res_q  [NUM_MODS];

    // One progress counter and resident flag per module.
    for (genvar g = 0; g < NUM_MODS; g++) begin : g_mod
        localparam logic [CNT_W-1:0] LAST = FRAMES[g*CNT_W +: CNT_W] - CNT_W'(1);
        logic sel;
        assign sel = (cur_id == ID_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prog_q[g] <= '0;
                res_q[g]  <= 1'b0;
            end else if (clr_mask[g]) begin
                prog_q[g] <= '0;
                res_q[g]  <= 1'b0;
            end else if (xfer && sel) begin
                if (prog_q[g] == LAST) begin
                    prog_q[g] <= '0;
                    res_q[g]  <= 1'b1;
                end else begin
                    prog_q[g] <= prog_q[g] + CNT_W'(1);
                end
            end
        end
    end

    logic [CNT_W-1:0] cur_frames;

    always_comb begin
        cur_prog   = '0;
        cur_frames = '0;
        for (int k = 0; k < NUM_MODS; k++) begin
            resident[k] = res_q[k];
            if (cur_id == ID_W'(k)) begin
                cur_prog   = prog_q[k];
                cur_frames = FRAMES[k*CNT_W +: CNT_W];
            end
        end
        last_frame = (cur_prog == cur_frames - CNT_W'(1));
    end

endmodule

// File: rtl/rl_fsm.sv
module rl_fsm
    import reconfig_pkg::*;
#(
    parameter int ID_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  rq_kind_e        kind,
    input  logic            req_valid,
    input  logic [ID_W-1:0] req_id,
    input  logic            xfer,
    input  logic            last_frame,
    output logic [ID_W-1:0] cur_id,
    output logic [ID_W-1:0] busy_id,
    output logic            cfg_valid,
    output logic            req_ack,
    output logic            done,
    output logic [ID_W-1:0] done_id
);

    ld_state_e       state_q, state_d;
    logic [ID_W-1:0] cur_q, cur_d;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        unique case (state_q)
            ST_IDLE: begin
                if (kind == RQ_START) begin
                    state_d = ST_LOAD;
                    cur_d   = req_id;
                end
            end
            ST_LOAD: begin
                if (kind == RQ_START) begin
                    cur_d = req_id;
                end else if (xfer && last_frame) begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
        end
    end

    // Registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_ack <= 1'b0;
            done    <= 1'b0;
            done_id <= '0;
        end else begin
            req_ack <= req_valid;
            done    <= xfer && last_frame;
            if (xfer && last_frame) begin
                done_id <= cur_q;
            end
        end
    end

    // State-decoded outputs.
    always_comb begin
        cur_id = cur_q;
        unique case (state_q)
            ST_IDLE: begin
                busy_id   = '1;
                cfg_valid = 1'b0;
            end
            ST_LOAD: begin
                busy_id   = cur_q;
                cfg_valid = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/reconfig_loader.sv
module reconfig_loader
    import reconfig_pkg::*;
#(
    parameter int NUM_MODS = 4,
    parameter int CNT_W    = 4,
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter logic [NUM_MODS*CNT_W-1:0]    FRAMES   = {4'd2, 4'd4, 4'd3, 4'd5},
    parameter logic [NUM_MODS*ADDR_W-1:0]   BASES    = {12'h300, 12'h200, 12'h100, 12'h000},
    parameter logic [NUM_MODS*NUM_MODS-1:0] CONFLICT = 16'h0252,
    localparam int ID_W = $clog2(NUM_MODS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [ID_W-1:0]     req_id,
    output logic                req_ack,
    output logic [ID_W-1:0]     busy_id,
    input  logic [ID_W-1:0]     query_id,
    output logic                query_loaded,
    output logic [NUM_MODS-1:0] resident,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                cfg_valid,
    input  logic                cfg_ready,
    output logic [DATA_W-1:0]   cfg_data,
    output logic                done,
    output logic [ID_W-1:0]     done_id
);

    rq_kind_e            kind;
    logic [NUM_MODS-1:0] clr_mask;
    logic [ID_W-1:0]     cur_id;
    logic [CNT_W-1:0]    cur_prog;
    logic                last_frame;
    logic                xfer;
    logic [ADDR_W-1:0]   cur_base;

    assign xfer     = cfg_valid && cfg_ready;
    assign cfg_data = mem_rdata;

    rl_req_decode #(
        .NUM_MODS (NUM_MODS),
        .ID_W     (ID_W),
        .CONFLICT (CONFLICT)
    ) u_dec (
        .req_valid (req_valid),
        .req_id    (req_id),
        .resident  (resident),
        .loading   (cfg_valid),
        .cur_id    (cur_id),
        .kind      (kind),
        .clr_mask  (clr_mask)
    );

    rl_fsm #(
        .ID_W (ID_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .kind       (kind),
        .req_valid  (req_valid),
        .req_id     (req_id),
        .xfer       (xfer),
        .last_frame (last_frame),
        .cur_id     (cur_id),
        .busy_id    (busy_id),
        .cfg_valid  (cfg_valid),
        .req_ack    (req_ack),
        .done       (done),
        .done_id    (done_id)
    );

    rl_progress_bank #(
        .NUM_MODS (NUM_MODS),
        .CNT_W    (CNT_W),
        .ID_W     (ID_W),
        .FRAMES   (FRAMES)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer       (xfer),
        .cur_id     (cur_id),
        .clr_mask   (clr_mask),
        .resident   (resident),
        .cur_prog   (cur_prog),
        .last_frame (last_frame)
    );

    // Frame address = module base + saved progress; resident lookup for the query port.
    always_comb begin
        cur_base     = '0;
        query_loaded = 1'b0;
        for (int k = 0; k < NUM_MODS; k++) begin
            if (cur_id == ID_W'(k)) begin
                cur_base = BASES[k*ADDR_W +: ADDR_W];
            end
            if (query_id == ID_W'(k)) begin
                query_loaded = resident[k];
            end
        end
        mem_addr = cur_base + ADDR_W'(cur_prog);
    end

endmodule

// File: rtl/rl_checker.sv
module rl_checker #(
    parameter int NUM_MODS = 4,
    parameter int ID_W     = 3,
    parameter int ADDR_W   = 12,
    parameter logic [NUM_MODS*NUM_MODS-1:0] CONFLICT = '0
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic [ID_W-1:0]     req_id,
    input logic                req_ack,
    input logic [ID_W-1:0]     busy_id,
    input logic [NUM_MODS-1:0] resident,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic                cfg_valid,
    input logic                cfg_ready,
    input logic                done,
    input logic [ID_W-1:0]     done_id
);

    localparam logic [ID_W-1:0] IDLE_ID = '1;

    logic req_res;
    logic req_in;
    logic done_res;
    logic idle;

    assign req_res  = |(resident & (NUM_MODS'(1) << req_id));
    assign done_res = |(resident & (NUM_MODS'(1) << done_id));
    assign req_in   = (req_id < ID_W'(NUM_MODS));
    assign idle     = (busy_id == IDLE_ID);

    AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && idle && req_in && !req_res) |=> (cfg_valid && busy_id == $past(req_id))); // R2

    AST_HOLD_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && !cfg_ready && !req_valid) |=> (cfg_valid && $stable(mem_addr) && $stable(busy_id))); // R3

    AST_DONE_RESIDENT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !$past(req_valid)) |-> (done_res && idle)); // R4

    AST_ACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> req_ack); // R7

    AST_DROP_RESIDENT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && idle && req_res) |=> (idle && $stable(resident))); // R7

    for (genvar i = 0; i < NUM_MODS; i++) begin : g_i
        for (genvar j = 0; j < NUM_MODS; j++) begin : g_j
            if (i != j && CONFLICT[i*NUM_MODS + j]) begin : g_pair
                AST_CONFLICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
                    !(resident[i] && resident[j])); // R5
                AST_LOADING_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                    (busy_id == ID_W'(i)) |-> !resident[j]); // R5
            end
        end
    end

endmodule

bind reconfig_loader rl_checker #(
    .NUM_MODS (NUM_MODS),
    .ID_W     (ID_W),
    .ADDR_W   (ADDR_W),
    .CONFLICT (CONFLICT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_id    (req_id),
    .req_ack   (req_ack),
    .busy_id   (busy_id),
    .resident  (resident),
    .mem_addr  (mem_addr),
    .cfg_valid (cfg_valid),
    .cfg_ready (cfg_ready),
    .done      (done),
    .done_id   (done_id)
);

// File: tb/reconfig_loader_tb.sv
module reconfig_loader_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [2:0]  req_id;
    logic        req_ack;
    logic [2:0]  busy_id;
    logic [2:0]  query_id;
    logic        query_loaded;
    logic [3:0]  resident;
    logic [11:0] mem_addr;
    logic [31:0] mem_rdata;
    logic        cfg_valid;
    logic        cfg_ready;
    logic [31:0] cfg_data;
    logic        done;
    logic [2:0]  done_id;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    // Memory model: each word carries a tag plus its own address.
    assign mem_rdata = {20'hA5A50, mem_addr};

    reconfig_loader u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_id       (req_id),
        .req_ack      (req_ack),
        .busy_id      (busy_id),
        .query_id     (query_id),
        .query_loaded (query_loaded),
        .resident     (resident),
        .mem_addr     (mem_addr),
        .mem_rdata    (mem_rdata),
        .cfg_valid    (cfg_valid),
        .cfg_ready    (cfg_ready),
        .cfg_data     (cfg_data),
        .done         (done),
        .done_id      (done_id)
    );

    typedef struct packed {
        logic [2:0]  id;
        logic [3:0]  frames;
        logic [11:0] base;
        logic [3:0]  res_start;
        logic [3:0]  res_end;
    } vec_t;

    // Full loads with the port always ready: id, frames, base, resident after start, after done.
    localparam vec_t VECS [4] = '{
        '{3'd0, 4'd5, 12'h000, 4'b0000, 4'b0001},
        '{3'd2, 4'd4, 12'h200, 4'b0001, 4'b0101},
        '{3'd3, 4'd2, 12'h300, 4'b0101, 4'b1101},
        '{3'd1, 4'd3, 12'h100, 4'b1000, 4'b1010}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic request(input logic [2:0] id);
        req_valid = 1'b1;
        req_id    = id;
        tick();
        req_valid = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 20000);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_id    = '0;
        query_id  = '0;
        cfg_ready = 1'b1;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        chk("R1 busy_id idle", 32'(busy_id), 32'h7);
        chk("R1 resident", 32'(resident), 32'h0);
        chk("R1 cfg_valid", 32'(cfg_valid), 32'h0);
        chk("R1 done", 32'(done), 32'h0);
        chk("R1 req_ack", 32'(req_ack), 32'h0);

        // Table walk: R2, R3, R4, R5
        for (int i = 0; i < 4; i++) begin
            request(VECS[i].id);
            chk("R7 ack", 32'(req_ack), 32'h1);
            chk("R2 busy_id", 32'(busy_id), 32'(VECS[i].id));
            chk("R2 cfg_valid", 32'(cfg_valid), 32'h1);
            chk("R5 resident at start", 32'(resident), 32'(VECS[i].res_start));
            for (int f = 0; f < 16; f++) begin
                if (f < int'(VECS[i].frames)) begin
                    chk("R3 mem_addr", 32'(mem_addr), 32'(VECS[i].base) + 32'(f));
                    chk("R3 cfg_data", cfg_data, {20'hA5A50, VECS[i].base + 12'(f)});
                    tick();
                end
            end
            chk("R4 done", 32'(done), 32'h1);
            chk("R4 done_id", 32'(done_id), 32'(VECS[i].id));
            chk("R4 busy_id idle", 32'(busy_id), 32'h7);
            chk("R4 resident", 32'(resident), 32'(VECS[i].res_end));
            tick();
            chk("R4 done one cycle", 32'(done), 32'h0);
        end

        // R7: dropped requests (resident 3, out-of-range 5, resident 1)
        request(3'd3);
        chk("R7 ack resident", 32'(req_ack), 32'h1);
        chk("R7 resident ignored", 32'(busy_id), 32'h7);
        request(3'd5);
        chk("R7 ack out of range", 32'(req_ack), 32'h1);
        chk("R7 out of range ignored", 32'(busy_id), 32'h7);
        request(3'd1);
        chk("R7 resident m1 ignored", 32'(busy_id), 32'h7);
        chk("R7 resident unchanged", 32'(resident), 32'b1010);

        // R8: query port
        query_id = 3'd1; #1;
        chk("R8 query m1", 32'(query_loaded), 32'h1);
        query_id = 3'd0; #1;
        chk("R8 query m0", 32'(query_loaded), 32'h0);
        query_id = 3'd6; #1;
        chk("R8 query out of range", 32'(query_loaded), 32'h0);

        // R3: backpressure on m0
        cfg_ready = 1'b0;
        request(3'd0);
        chk("R2 busy m0", 32'(busy_id), 32'h0);
        chk("R5 m1 cleared by m0", 32'(resident), 32'b1000);
        tick();
        chk("R3 addr hold", 32'(mem_addr), 32'h000);
        chk("R3 valid hold", 32'(cfg_valid), 32'h1);
        cfg_ready = 1'b1;
        tick();
        chk("R3 addr step 1", 32'(mem_addr), 32'h001);
        tick();
        chk("R3 addr step 2", 32'(mem_addr), 32'h002);
        cfg_ready = 1'b0;

        // R6: preempt m0 with m2, then resume m0
        request(3'd2);
        chk("R6 preempt busy", 32'(busy_id), 32'h2);
        chk("R6 preempt addr", 32'(mem_addr), 32'h200);
        cfg_ready = 1'b1;
        tick();
        cfg_ready = 1'b0;
        chk("R6 m2 advanced", 32'(mem_addr), 32'h201);
        request(3'd0);
        chk("R6 resume busy", 32'(busy_id), 32'h0);
        chk("R6 resume addr", 32'(mem_addr), 32'h002);

        // R5: m1 overwrites m0 and m2 progress
        request(3'd1);
        chk("R5 busy m1", 32'(busy_id), 32'h1);
        chk("R5 m1 addr", 32'(mem_addr), 32'h100);
        chk("R5 m3 stays resident", 32'(resident), 32'b1000);
        request(3'd0);
        chk("R5 m0 progress reset", 32'(mem_addr), 32'h000);
        request(3'd2);
        chk("R5 m2 progress reset", 32'(mem_addr), 32'h200);

        // R7: request for the module already loading
        request(3'd2);
        chk("R7 same id ack", 32'(req_ack), 32'h1);
        chk("R7 same id busy", 32'(busy_id), 32'h2);
        chk("R7 same id addr", 32'(mem_addr), 32'h200);

        // Finish m2
        cfg_ready = 1'b1;
        for (int f = 0; f < 4; f++) begin
            chk("R3 m2 addr", 32'(mem_addr), 32'h200 + 32'(f));
            tick();
        end
        chk("R4 m2 done", 32'(done), 32'h1);
        chk("R4 m2 done_id", 32'(done_id), 32'h2);
        chk("R4 m2 resident", 32'(resident), 32'b1100);
        query_id = 3'd2; #1;
        chk("R8 query m2", 32'(query_loaded), 32'h1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule